// File: doc/BRIEF.md
# Two-tier prioritized interrupt controller

The controller gathers fifteen request lines, numbered 1 to 15, and turns each 0-to-1 transition into a latched request bit. Those latched bits are combined with bits that software forces. The result is gated by an enable mask for processor 0. It is then split into an urgent tier and a normal tier using a per-line tier register. The processor receives a single 4-bit code that names the winning line. When the processor acknowledges that code, the matching latched and forced bits are dropped.

Software reaches the controller through a 32-bit register bus. Each access is a one-cycle strobe, and read data appears one cycle after the read. Each line can be set to bypass the latch: a request on such a line marks that line in the forced set of every processor. Mask, force and spare registers exist for several processors. Only processor 0 is wired to the output.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After a synchronous reset, every register reads 0, `irq_level` is 0 and `bus_rdata` is 0. The input edge sampler also starts at 0.
- R2: The active set is (latched OR forced0) AND mask0 over bits 15:1. The urgent tier is the active bits whose tier bit is 1. The normal tier is the remaining active bits. `irq_level` shows the highest-numbered bit of the urgent tier when that tier is non-empty, otherwise the highest-numbered bit of the normal tier, otherwise 0. It settles one cycle after the state that feeds it changes.
- R3: While `ack_valid` is high, the bit selected by `ack_num[3:0]` is cleared in both the latched register and forced0. `ack_num[4]` is ignored.
- R4: A line i counts as rising when it is 1 in the current cycle and was 0 in the previous cycle. A rising line i sets latched bit i, unless broadcast bit i is 1. In that case it sets bit i in the force register of every processor instead. A rising line beats an acknowledge or a clear of the same bit in the same cycle.
- R5: Byte offsets are: 0x00 tier, 0x04 latched (read only), 0x08 forced0 alias, 0x0C clear-latched (write 1 to clear), 0x10 status, 0x14 broadcast. Per-processor registers sit at 0x40+4c (mask), 0x80+4c (force) and 0xC0+4c (spare).
- R6: A write to force register c computes (old OR data[15:1]) AND NOT data[31:17]. A write to the alias at 0x08 replaces forced0 with data[15:1].
- R7: Bit 0 is never stored. The tier, force and broadcast registers keep bits 15:1, mask keeps bits 31:1, and spare keeps bits 3:0.
- R8: Writes to 0x04 and 0x10 change nothing. Reads of 0x0C and 0x10 return 0.
- R9: Only accesses with `bus_be` = 4'hF act. Any other write is dropped, and any other read returns 0. Only `bus_addr[7:0]` is decoded.
- R10: Offsets that are unaligned, unlisted, or that name a processor index of NCPU or above read 0 and ignore writes.
- R11: Spare registers, and mask and force registers of processors other than 0, have no effect on `irq_level`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 16 | Request lines, bit 0 unused |
| bus_req | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address, low 8 bits decoded |
| bus_be | input | 4 | Byte enables, must be all ones |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the read |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_num | input | 5 | Acknowledged line number |
| irq_level | output | 4 | Encoded winning line, 0 = none |

## Verification
The hardest case to reach from the ports is a collision between a fresh rising edge and an acknowledge or a clear of the same bit in one cycle. The bench forces this by driving the line and `ack_valid` in the same cycle. A second hard case is a broadcast request that lands in other processors' force registers. Those registers are invisible at `irq_level`, so the bench reads them back over the bus after the acknowledge and expects the bits to remain. Tier ordering is swept with pseudo-random tier, force and mask words written through the alias, and each result is compared against an arithmetic model of the two tiers.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int unsigned LINES = 16;

  localparam logic [7:0] OFF_TIER   = 8'h00;
  localparam logic [7:0] OFF_LATCH  = 8'h04;
  localparam logic [7:0] OFF_FALIAS = 8'h08;
  localparam logic [7:0] OFF_CLR    = 8'h0C;
  localparam logic [7:0] OFF_STAT   = 8'h10;
  localparam logic [7:0] OFF_BCAST  = 8'h14;

  typedef enum logic [3:0] {
    K_NONE, K_TIER, K_LATCH, K_FALIAS, K_CLR, K_STAT, K_BCAST,
    K_MASK, K_FORCE, K_SPARE
  } reg_kind_t;

  function automatic logic [3:0] top_bit(input logic [LINES-1:0] v);
    logic [3:0] r;
    r = 4'd0;
    for (int i = 1; i < LINES; i++)
      if (v[i]) r = 4'(i);
    return r;
  endfunction
endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
  import prio_irq_pkg::*;
#(
  parameter int NCPU = 4,
  localparam int CW = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic [7:0]    off,
  output reg_kind_t     kind,
  output logic [CW-1:0] cpu
);
  logic idx_ok;
  assign idx_ok = (32'(off[5:2]) < NCPU);
  assign cpu    = CW'(off[5:2]);

  always_comb begin
    kind = K_NONE;
    if (off[1:0] == 2'b00) begin
      unique case (off[7:6])
        2'b00: begin
          case (off)
            OFF_TIER:   kind = K_TIER;
            OFF_LATCH:  kind = K_LATCH;
            OFF_FALIAS: kind = K_FALIAS;
            OFF_CLR:    kind = K_CLR;
            OFF_STAT:   kind = K_STAT;
            OFF_BCAST:  kind = K_BCAST;
            default:    kind = K_NONE;
          endcase
        end
        2'b01: if (idx_ok) kind = K_MASK;
        2'b10: if (idx_ok) kind = K_FORCE;
        2'b11: if (idx_ok) kind = K_SPARE;
        default: kind = K_NONE;
      endcase
    end
  end
endmodule

// File: rtl/irq_edge_capture.sv
module irq_edge_capture
  import prio_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] irq_in,
  input  logic [LINES-1:0] bcast,
  output logic [LINES-1:0] to_latch,
  output logic [LINES-1:0] to_force
);
  logic [LINES-1:0] prev_q;
  logic [LINES-1:0] rise;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= irq_in;
  end

  assign rise     = irq_in & ~prev_q & {{(LINES-1){1'b1}}, 1'b0};
  assign to_latch = rise & ~bcast;
  assign to_force = rise & bcast;
endmodule

// File: rtl/irq_cpu_bank.sv
module irq_cpu_bank
  import prio_irq_pkg::*;
#(
  parameter int NCPU = 4,
  localparam int CW = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_mask,
  input  logic             wr_force,
  input  logic             wr_spare,
  input  logic             wr_alias,
  input  logic [CW-1:0]    sel,
  input  logic [31:0]      wdata,
  input  logic [LINES-1:0] ack_clr,
  input  logic [LINES-1:0] bcast_set,
  output logic [31:0]      mask0,
  output logic [LINES-1:0] force0,
  output logic [31:0]      mask_rd,
  output logic [LINES-1:0] force_rd,
  output logic [3:0]       spare_rd
);
  logic [31:0]      mask_arr  [NCPU];
  logic [LINES-1:0] force_arr [NCPU];
  logic [3:0]       spare_arr [NCPU];
  logic [LINES-1:0] set_bits, clr_bits;
  wire unused_wbits = &{1'b0, wdata[16], wdata[0]};

  assign set_bits = {wdata[15:1], 1'b0};
  assign clr_bits = {wdata[31:17], 1'b0};

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    logic [31:0]      mask_q;
    logic [LINES-1:0] force_q, force_nxt;
    logic [3:0]       spare_q;
    logic             hit;
    assign hit = (sel == CW'(c));

    always_comb begin
      force_nxt = force_q;
      if (wr_force && hit) force_nxt = (force_q | set_bits) & ~clr_bits;
      if (c == 0) begin
        if (wr_alias) force_nxt = set_bits;
        force_nxt = force_nxt & ~ack_clr;
      end
      force_nxt = force_nxt | bcast_set;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        mask_q  <= '0;
        force_q <= '0;
        spare_q <= '0;
      end else begin
        if (wr_mask && hit)  mask_q  <= {wdata[31:1], 1'b0};
        if (wr_spare && hit) spare_q <= wdata[3:0];
        force_q <= force_nxt;
      end
    end

    assign mask_arr[c]  = mask_q;
    assign force_arr[c] = force_q;
    assign spare_arr[c] = spare_q;
  end

  assign mask0    = mask_arr[0];
  assign force0   = force_arr[0];
  assign mask_rd  = mask_arr[sel];
  assign force_rd = force_arr[sel];
  assign spare_rd = spare_arr[sel];
endmodule

// File: rtl/irq_prio_select.sv
module irq_prio_select
  import prio_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] active,
  input  logic [LINES-1:0] tier,
  output logic [3:0]       level
);
  logic [LINES-1:0] urgent, normal, chosen;
  assign urgent = active & tier;
  assign normal = active & ~tier;
  assign chosen = (|urgent) ? urgent : normal;

  always_ff @(posedge clk) begin
    if (rst) level <= 4'd0;
    else     level <= top_bit(chosen);
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int NCPU = 4,
  localparam int CW = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [15:0] irq_in,
  input  logic        bus_req,
  input  logic        bus_we,
  input  logic [31:0] bus_addr,
  input  logic [3:0]  bus_be,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        ack_valid,
  input  logic [4:0]  ack_num,
  output logic [3:0]  irq_level
);
  reg_kind_t        kind;
  logic [CW-1:0]    cpu;
  logic             full, wr, rd;
  logic [LINES-1:0] latch_q, tier_q, bcast_q;
  logic [LINES-1:0] to_latch, to_force, ack_clr, clr_bits;
  logic [31:0]      mask0, mask_rd;
  logic [LINES-1:0] force0, force_rd;
  logic [3:0]       spare_rd;
  logic [31:0]      rd_val;
  wire unused_in = &{1'b0, bus_addr[31:8], ack_num[4]};

  irq_bus_decode #(.NCPU(NCPU)) u_dec (
    .off(bus_addr[7:0]), .kind(kind), .cpu(cpu)
  );

  assign full = (bus_be == 4'hF);
  assign wr   = bus_req && bus_we && full;
  assign rd   = bus_req && !bus_we;

  irq_edge_capture u_edge (
    .clk(clk), .rst(rst), .irq_in(irq_in), .bcast(bcast_q),
    .to_latch(to_latch), .to_force(to_force)
  );

  assign ack_clr  = ack_valid ? (LINES'(1) << ack_num[3:0]) : '0;
  assign clr_bits = (wr && kind == K_CLR) ? {bus_wdata[15:1], 1'b0} : '0;

  irq_cpu_bank #(.NCPU(NCPU)) u_bank (
    .clk(clk), .rst(rst),
    .wr_mask (wr && kind == K_MASK),
    .wr_force(wr && kind == K_FORCE),
    .wr_spare(wr && kind == K_SPARE),
    .wr_alias(wr && kind == K_FALIAS),
    .sel(cpu), .wdata(bus_wdata), .ack_clr(ack_clr), .bcast_set(to_force),
    .mask0(mask0), .force0(force0),
    .mask_rd(mask_rd), .force_rd(force_rd), .spare_rd(spare_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '0;
      tier_q  <= '0;
      bcast_q <= '0;
    end else begin
      latch_q <= (latch_q & ~clr_bits & ~ack_clr) | to_latch;
      if (wr && kind == K_TIER)  tier_q  <= {bus_wdata[15:1], 1'b0};
      if (wr && kind == K_BCAST) bcast_q <= {bus_wdata[15:1], 1'b0};
    end
  end

  irq_prio_select u_sel (
    .clk(clk), .rst(rst),
    .active((latch_q | force0) & mask0[LINES-1:0]),
    .tier(tier_q), .level(irq_level)
  );

  always_comb begin
    case (kind)
      K_TIER:   rd_val = {16'h0, tier_q};
      K_LATCH:  rd_val = {16'h0, latch_q};
      K_FALIAS: rd_val = {16'h0, force0};
      K_BCAST:  rd_val = {16'h0, bcast_q};
      K_MASK:   rd_val = mask_rd;
      K_FORCE:  rd_val = {16'h0, force_rd};
      K_SPARE:  rd_val = {28'h0, spare_rd};
      default:  rd_val = 32'h0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     bus_rdata <= 32'h0;
    else if (rd) bus_rdata <= full ? rd_val : 32'h0;
  end
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk (
  input logic        clk,
  input logic        rst,
  input logic [15:0] irq_in,
  input logic        bus_req,
  input logic        bus_we,
  input logic [3:0]  bus_be,
  input logic [31:0] bus_rdata,
  input logic        ack_valid,
  input logic [4:0]  ack_num,
  input logic [3:0]  irq_level,
  input logic [15:0] latch_q,
  input logic [15:0] tier_q,
  input logic [15:0] bcast_q,
  input logic [15:0] force0,
  input logic [31:0] mask0
);
  logic [15:0] prev_in, rise, act, rise_l_d, rise_f_d, tier_d;
  logic [3:0]  ack_d;
  assign rise = irq_in & ~prev_in & 16'hFFFE;
  assign act  = (latch_q | force0) & mask0[15:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_in <= '0; rise_l_d <= '0; rise_f_d <= '0; tier_d <= '0; ack_d <= '0;
    end else begin
      prev_in  <= irq_in;
      rise_l_d <= rise & ~bcast_q;
      rise_f_d <= rise & bcast_q;
      tier_d   <= tier_q;
      ack_d    <= ack_num[3:0];
    end
  end

  // R2: an urgent active bit makes the next output an urgent line
  a_r2_urgent_first: assert property (@(posedge clk) disable iff (rst)
    (|(act & tier_q)) |=> tier_d[irq_level]);

  // R2: nothing active gives a zero code
  a_r2_idle_zero: assert property (@(posedge clk) disable iff (rst)
    (act == 16'h0) |=> (irq_level == 4'd0));

  // R3: acknowledge clears both copies when nothing else touches the bit
  a_r3_ack_clears: assert property (@(posedge clk) disable iff (rst)
    (ack_valid && !(bus_req && bus_we) && !rise[ack_num[3:0]])
    |=> (!latch_q[ack_d] && !force0[ack_d]));

  // R4: rising edges land in latch or forced0
  a_r4_rise_latched: assert property (@(posedge clk) disable iff (rst)
    (|(rise & ~bcast_q)) |=> ((latch_q & rise_l_d) == rise_l_d));

  a_r4_rise_forced: assert property (@(posedge clk) disable iff (rst)
    (|(rise & bcast_q)) |=> ((force0 & rise_f_d) == rise_f_d));

  // R9: a partial read returns zero
  a_r9_partial_read: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_we && bus_be != 4'hF) |=> (bus_rdata == 32'h0));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .irq_in(irq_in), .bus_req(bus_req),
  .bus_we(bus_we), .bus_be(bus_be), .bus_rdata(bus_rdata),
  .ack_valid(ack_valid), .ack_num(ack_num), .irq_level(irq_level),
  .latch_q(latch_q), .tier_q(tier_q), .bcast_q(bcast_q),
  .force0(force0), .mask0(mask0)
);

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;
  localparam int CLK_NS = 10;
  localparam int NCPU   = 4;

  logic        clk = 0, rst = 1;
  logic [15:0] irq_in = '0;
  logic        bus_req = 0, bus_we = 0, ack_valid = 0;
  logic [31:0] bus_addr = '0, bus_wdata = '0, bus_rdata;
  logic [3:0]  bus_be = 4'hF, irq_level;
  logic [4:0]  ack_num = '0;

  int n_tests = 0, n_fail = 0;

  prio_irq_ctrl #(.NCPU(NCPU)) uut (
    .clk(clk), .rst(rst), .irq_in(irq_in), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .ack_valid(ack_valid), .ack_num(ack_num),
    .irq_level(irq_level)
  );

  always #(CLK_NS/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
    @(negedge clk);
    bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_req = 0; bus_we = 0; bus_be = 4'hF;
  endtask

  task automatic rd(input logic [31:0] a, output logic [31:0] d, input logic [3:0] be = 4'hF);
    @(negedge clk);
    bus_req = 1; bus_we = 0; bus_addr = a; bus_be = be;
    @(negedge clk);
    bus_req = 0; bus_be = 4'hF;
    d = bus_rdata;
  endtask

  task automatic pulse(input logic [15:0] b);
    @(negedge clk); irq_in = b;
    @(negedge clk); irq_in = '0;
  endtask

  task automatic ack(input logic [4:0] n);
    @(negedge clk); ack_valid = 1; ack_num = n;
    @(negedge clk); ack_valid = 0;
  endtask

  function automatic logic [3:0] model(input logic [15:0] lat, input logic [15:0] frc,
                                       input logic [15:0] msk, input logic [15:0] tr);
    logic [15:0] a, g;
    logic [3:0]  r;
    a = (lat | frc) & msk & 16'hFFFE;
    g = ((a & tr) != 0) ? (a & tr) : (a & ~tr);
    r = 0;
    for (int i = 1; i < 16; i++) if (g[i]) r = 4'(i);
    return r;
  endfunction

  initial begin
    #(CLK_NS * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d, s;
    logic [15:0] tr, fr, mk;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1 level", {28'h0, irq_level}, 0);
    check("R1 rdata", bus_rdata, 0);
    foreach (d[i]) ;
    rd(32'h00, d); check("R1 tier", d, 0);
    rd(32'h04, d); check("R1 latch", d, 0);
    rd(32'h08, d); check("R1 force0", d, 0);
    rd(32'h14, d); check("R1 bcast", d, 0);
    rd(32'h44, d); check("R1 mask1", d, 0);
    rd(32'hC0, d); check("R1 spare0", d, 0);

    // R7 bit trimming
    wr(32'h40, 32'hFFFF_FFFF); rd(32'h40, d); check("R7 mask", d, 32'hFFFF_FFFE);
    wr(32'h00, 32'hFFFF_FFFF); rd(32'h00, d); check("R7 tier", d, 32'h0000_FFFE);
    wr(32'h14, 32'hFFFF_FFFF); rd(32'h14, d); check("R7 bcast", d, 32'h0000_FFFE);
    wr(32'hC4, 32'hFFFF_FFFF); rd(32'hC4, d); check("R7 spare", d, 32'h0000_000F);
    wr(32'h14, 0); wr(32'h00, 0);

    // R2 R4 R3 line sweep
    for (int i = 1; i < 16; i++) begin
      pulse(16'(1) << i);
      @(negedge clk);
      check($sformatf("R2 sweep line %0d", i), {28'h0, irq_level}, i);
      rd(32'h04, d); check("R4 latched", d, 32'(1) << i);
      ack(5'(i));
      rd(32'h04, d); check("R3 ack cleared", d, 0);
      check("R2 idle after ack", {28'h0, irq_level}, 0);
    end

    // R2 urgent tier beats higher normal line
    wr(32'h00, 32'h0000_0008);
    pulse(16'h1008); @(negedge clk);
    check("R2 urgent tier", {28'h0, irq_level}, 3);
    ack(5'd3); @(negedge clk);
    check("R2 normal after urgent ack", {28'h0, irq_level}, 12);
    ack(5'd12); wr(32'h00, 0);

    // R4 rising edge beats acknowledge; R3 ack_num[4] ignored
    @(negedge clk); irq_in = 16'h0040; ack_valid = 1; ack_num = 5'd6;
    @(negedge clk); irq_in = 0; ack_valid = 0;
    rd(32'h04, d); check("R4 request wins", d, 32'h40);
    ack(5'h16);
    rd(32'h04, d); check("R3 high ack bit ignored", d, 0);

    // R8 latched write ignored, clear register, status
    pulse(16'h0004); pulse(16'h0010);
    wr(32'h04, 32'h0); rd(32'h04, d); check("R8 latch write ignored", d, 32'h14);
    rd(32'h0C, d); check("R8 clear reads 0", d, 0);
    wr(32'h10, 32'hFFFF_FFFF); rd(32'h10, d); check("R8 status reads 0", d, 0);
    wr(32'h0C, 32'h0000_0004); rd(32'h04, d); check("R5 clear one bit", d, 32'h10);
    wr(32'h0C, 32'hFFFF_FFFF); rd(32'h04, d); check("R5 clear all", d, 0);

    // R4 broadcast into all force registers
    wr(32'h14, 32'h0000_0200);
    pulse(16'h0200);
    rd(32'h04, d); check("R4 bcast not latched", d, 0);
    rd(32'h08, d); check("R4 bcast force0", d, 32'h200);
    rd(32'h84, d); check("R4 bcast force1", d, 32'h200);
    ack(5'd9);
    rd(32'h08, d); check("R3 ack clears force0", d, 0);
    rd(32'h84, d); check("R3 ack leaves force1", d, 32'h200);
    wr(32'h14, 0);

    // R6 set/clear halves and alias
    wr(32'h80, 32'h0000_00F0);
    wr(32'h80, 32'h0031_0103);
    rd(32'h08, d); check("R6 set clear", d, 32'h1C2);
    wr(32'h08, 32'hFFFF_0005);
    rd(32'h80, d); check("R6 alias replace", d, 32'h4);
    wr(32'h08, 0);

    // R9 byte enables and address folding
    wr(32'h00, 32'h0000_0030);
    wr(32'h00, 32'h0000_00F0, 4'h3); rd(32'h00, d); check("R9 partial write", d, 32'h30);
    rd(32'h00, d, 4'h1); check("R9 partial read", d, 0);
    wr(32'hABCD_EF00, 32'h0000_0006); rd(32'h1234_5600, d); check("R9 addr fold", d, 32'h6);
    wr(32'h00, 0);

    // R10 unmapped offsets
    wr(32'h18, 32'hFFFF_FFFF); rd(32'h18, d); check("R10 hole", d, 0);
    wr(32'h40 + 4*NCPU, 32'hFFFF_FFFF); rd(32'h40 + 4*NCPU, d); check("R10 cpu range", d, 0);
    rd(32'h02, d); check("R10 unaligned", d, 0);

    // R11 other processors and spare have no effect
    wr(32'h40, 0);
    wr(32'h44, 32'hFFFF_FFFF); wr(32'h84, 32'h0000_FFFE); wr(32'h08, 32'h0000_8000);
    @(negedge clk);
    check("R11 mask0 zero", {28'h0, irq_level}, 0);
    wr(32'h40, 32'hFFFF_FFFF); @(negedge clk);
    check("R11 force0 only", {28'h0, irq_level}, 15);
    wr(32'hC0, 32'h0000_0003); @(negedge clk);
    check("R11 spare no effect", {28'h0, irq_level}, 15);

    // R2 pseudo-random tier sweep
    s = 32'h1357_9BDF;
    for (int k = 0; k < 48; k++) begin
      s = s * 32'd1103515245 + 32'd12345; tr = s[31:16];
      s = s * 32'd1103515245 + 32'd12345; fr = s[31:16];
      s = s * 32'd1103515245 + 32'd12345; mk = s[31:16];
      wr(32'h00, {16'h0, tr}); wr(32'h08, {16'h0, fr}); wr(32'h40, {16'hFFFF, mk});
      @(negedge clk);
      check($sformatf("R2 sweep %0d", k), {28'h0, irq_level},
            {28'h0, model(16'h0, fr, mk, tr)});
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule